// File: doc/BRIEF.md
# Floppy Controller Register Bank

This block holds the registers a host processor sees on a floppy disk formatter/controller: a command register, a status register, a track register, a sector register and a data register. All of them share one 8-bit bus with a 2-bit register select, a chip select and separate read and write strobes. The bidirectional bus is split into a write-data input, a read-data output and an output enable that an outer pad ring turns into a tri-state driver.

The bank applies the access rules of the controller. Command is write-only, and its address reads back status. Status cannot be written from the host. While the command sequencer reports busy, host loads of track, sector and command are refused. A force-interrupt command is the one exception and is always taken. The track register counts head step pulses and saturates at both ends. The track and sector registers are compared against the ID field the disk side delivers. A write command that arrives while the medium is write-protected is aborted, and the write-protect status bit is set.

The data register is exposed as the seek target for the sequencer. Serial data handling, step timing, the checksum logic and the command sequencing itself live outside this block.

Top module: `fdc_regbank`

## Requirements
- R1: After reset the track, sector, data, command and status registers are all zero. `cmd_start`, `wp_abort`, `trk_match` and `sec_match` are low.
- R2: A host write (cs=1, wr=1) to select 1 loads track, to select 2 loads sector, and to select 3 loads data. A host read of the same select returns that value.
- R3: A read of select 0 returns status, never the command. Bit 0 is the live `busy` input and bits 7..1 are the status register. Host writes never change bits 7..1, except the bit-6 rule in R9.
- R4: When `seq_stat_we` is high, status bits 7..1 load from `seq_stat` on the next clock.
- R5: While `busy` is high, host writes to track, sector and command are ignored. Writes to data are still accepted.
- R6: A command whose upper nibble is 4'hD (force interrupt) is accepted even while busy. It appears on `cmd_code`, and `cmd_start` pulses for one cycle after the write clock.
- R7: A `step` pulse with `step_in`=1 adds one to the track register, and one with `step_in`=0 subtracts one. The count stays at 255 and at 0 instead of wrapping. A host track write in the same cycle wins over the step.
- R8: On a clock with `id_valid` high, `trk_match` and `sec_match` register whether `id_trk` and `id_sec` equal the track and sector values held before that edge. They hold until the next `id_valid`.
- R9: A write command has upper bits 3'b101 or upper nibble 4'hF. If one is accepted while `wprot_n` is low, `wp_abort` pulses instead of `cmd_start` and status bit 6 is set. Any other accepted command pulses `cmd_start` and clears status bit 6.
- R10: `rdata_oe` is high exactly when cs and rd are both high. `rdata` is zero whenever `rdata_oe` is low.
- R11: `seek_target` always shows the data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select, active high |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| addr | input | 2 | Register select |
| wdata | input | 8 | Bus data from host |
| rdata | output | 8 | Bus data to host |
| rdata_oe | output | 1 | Drive enable for the bus |
| busy | input | 1 | Sequencer busy |
| seq_stat_we | input | 1 | Status load strobe from sequencer |
| seq_stat | input | 7 | Status bits 7..1 from sequencer |
| step | input | 1 | Head step pulse |
| step_in | input | 1 | Step direction, 1 toward inner tracks |
| id_valid | input | 1 | ID field values valid |
| id_trk | input | 8 | Track number read from the ID field |
| id_sec | input | 8 | Sector number read from the ID field |
| trk_match | output | 1 | Track compare result |
| sec_match | output | 1 | Sector compare result |
| wprot_n | input | 1 | Write protect, active low |
| cmd_code | output | 8 | Last accepted command |
| cmd_start | output | 1 | Command accepted pulse |
| wp_abort | output | 1 | Write command aborted pulse |
| seek_target | output | 8 | Data register for seeks |

## Verification
The bench builds the bank with the default 8-bit register width. This width brings both saturation limits of the track count (0 and 255) within a few step pulses of a host load. It also makes the force-interrupt and write-command encodings exact nibble patterns. A behavioural model is compared every cycle against all outputs and the read mux. The bench exercises lockout under busy, force interrupt while busy, and a step colliding with a track write. It also covers write-protect aborts followed by an accepted command that clears the status bit.

// File: rtl/fdc_regbank_pkg.sv
package fdc_regbank_pkg;
  typedef enum logic [1:0] {
    SEL_CMD_STAT = 2'd0,
    SEL_TRACK    = 2'd1,
    SEL_SECTOR   = 2'd2,
    SEL_DATA     = 2'd3
  } reg_sel_e;

  localparam logic [3:0] FORCE_INT_NIB = 4'hD;
  localparam logic [2:0] WR_SECT_TOP   = 3'b101;
  localparam logic [3:0] WR_TRK_NIB    = 4'hF;
  localparam int unsigned WP_BIT       = 6;
  localparam int unsigned RST_STAGES   = 2;
endpackage

// File: rtl/fdc_rst_sync.sv
module fdc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= 1'b1;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/fdc_track_ctr.sv
module fdc_track_ctr #(
  parameter int unsigned REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [REG_W-1:0] load_val,
  input  logic             step,
  input  logic             step_in,
  output logic [REG_W-1:0] trk_q
);
  localparam logic [REG_W-1:0] TRK_MAX = '1;
  localparam logic [REG_W-1:0] TRK_MIN = '0;
  localparam logic [REG_W-1:0] ONE     = {{(REG_W-1){1'b0}}, 1'b1};

  logic [REG_W-1:0] trk_d;
  logic             trk_en;

  always_comb begin
    trk_d  = trk_q;
    trk_en = 1'b0;
    if (load_en) begin
      trk_d  = load_val;
      trk_en = 1'b1;
    end else if (step && step_in && (trk_q != TRK_MAX)) begin
      trk_d  = trk_q + ONE;
      trk_en = 1'b1;
    end else if (step && !step_in && (trk_q != TRK_MIN)) begin
      trk_d  = trk_q - ONE;
      trk_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      trk_q <= '0;
    else if (trk_en) trk_q <= trk_d;
  end
endmodule

// File: rtl/fdc_cmd_gate.sv
module fdc_cmd_gate
  import fdc_regbank_pkg::*;
#(
  parameter int unsigned REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_cmd,
  input  logic [REG_W-1:0] wdata,
  input  logic             busy,
  input  logic             wprot_n,
  output logic             wp_set,
  output logic             wp_clr,
  output logic [REG_W-1:0] cmd_q,
  output logic             cmd_start,
  output logic             wp_abort
);
  logic is_fint, is_write, accept, abort_d, start_d;

  always_comb begin
    is_fint  = (wdata[REG_W-1 -: 4] == FORCE_INT_NIB);
    is_write = (wdata[REG_W-1 -: 3] == WR_SECT_TOP) ||
               (wdata[REG_W-1 -: 4] == WR_TRK_NIB);
    accept   = wr_cmd && (!busy || is_fint);
    abort_d  = accept && is_write && !wprot_n;
    start_d  = accept && !abort_d;
  end

  assign wp_set = abort_d;
  assign wp_clr = start_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmd_q <= '0;
    else if (accept) cmd_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_start <= 1'b0;
      wp_abort  <= 1'b0;
    end else begin
      cmd_start <= start_d;
      wp_abort  <= abort_d;
    end
  end
endmodule

// File: rtl/fdc_id_cmp.sv
module fdc_id_cmp #(
  parameter int unsigned REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             id_valid,
  input  logic [REG_W-1:0] id_trk,
  input  logic [REG_W-1:0] id_sec,
  input  logic [REG_W-1:0] trk_q,
  input  logic [REG_W-1:0] sec_q,
  output logic             trk_match,
  output logic             sec_match
);
  logic tm_d, sm_d;

  always_comb begin
    tm_d = (id_trk == trk_q);
    sm_d = (id_sec == sec_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trk_match <= 1'b0;
      sec_match <= 1'b0;
    end else if (id_valid) begin
      trk_match <= tm_d;
      sec_match <= sm_d;
    end
  end
endmodule

// File: rtl/fdc_regbank.sv
module fdc_regbank
  import fdc_regbank_pkg::*;
#(
  parameter int unsigned REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs,
  input  logic             rd,
  input  logic             wr,
  input  logic [1:0]       addr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output logic             rdata_oe,
  input  logic             busy,
  input  logic             seq_stat_we,
  input  logic [REG_W-1:1] seq_stat,
  input  logic             step,
  input  logic             step_in,
  input  logic             id_valid,
  input  logic [REG_W-1:0] id_trk,
  input  logic [REG_W-1:0] id_sec,
  output logic             trk_match,
  output logic             sec_match,
  input  logic             wprot_n,
  output logic [REG_W-1:0] cmd_code,
  output logic             cmd_start,
  output logic             wp_abort,
  output logic [REG_W-1:0] seek_target
);
  logic             srst_n;
  reg_sel_e         sel;
  logic             bus_wr, wr_trk, wr_sec, wr_dat, wr_cmd;
  logic [REG_W-1:0] trk_q, sec_q, sec_d, dat_q, dat_d;
  logic [REG_W-1:1] st_q, st_d;
  logic             st_en;
  logic             wp_set, wp_clr;
  logic [REG_W-1:0] rd_mux;

  fdc_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  always_comb begin
    sel    = reg_sel_e'(addr);
    bus_wr = cs && wr;
    wr_trk = bus_wr && (sel == SEL_TRACK)  && !busy;
    wr_sec = bus_wr && (sel == SEL_SECTOR) && !busy;
    wr_dat = bus_wr && (sel == SEL_DATA);
    wr_cmd = bus_wr && (sel == SEL_CMD_STAT);
  end

  fdc_track_ctr #(.REG_W(REG_W)) u_track (
    .clk      (clk),
    .rst_n    (srst_n),
    .load_en  (wr_trk),
    .load_val (wdata),
    .step     (step),
    .step_in  (step_in),
    .trk_q    (trk_q)
  );

  fdc_cmd_gate #(.REG_W(REG_W)) u_cmd (
    .clk       (clk),
    .rst_n     (srst_n),
    .wr_cmd    (wr_cmd),
    .wdata     (wdata),
    .busy      (busy),
    .wprot_n   (wprot_n),
    .wp_set    (wp_set),
    .wp_clr    (wp_clr),
    .cmd_q     (cmd_code),
    .cmd_start (cmd_start),
    .wp_abort  (wp_abort)
  );

  fdc_id_cmp #(.REG_W(REG_W)) u_idcmp (
    .clk       (clk),
    .rst_n     (srst_n),
    .id_valid  (id_valid),
    .id_trk    (id_trk),
    .id_sec    (id_sec),
    .trk_q     (trk_q),
    .sec_q     (sec_q),
    .trk_match (trk_match),
    .sec_match (sec_match)
  );

  // sector and data next state
  always_comb begin
    sec_d = wr_sec ? wdata : sec_q;
    dat_d = wr_dat ? wdata : dat_q;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)     sec_q <= '0;
    else if (wr_sec) sec_q <= sec_d;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)     dat_q <= '0;
    else if (wr_dat) dat_q <= dat_d;
  end

  // status: sequencer load first, then the write-protect bit rule on top
  always_comb begin
    st_d  = st_q;
    st_en = seq_stat_we || wp_set || wp_clr;
    if (seq_stat_we) st_d = seq_stat;
    if (wp_set)      st_d[WP_BIT] = 1'b1;
    else if (wp_clr) st_d[WP_BIT] = 1'b0;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)    st_q <= '0;
    else if (st_en) st_q <= st_d;
  end

  // read path
  always_comb begin
    unique case (sel)
      SEL_CMD_STAT: rd_mux = {st_q, busy};
      SEL_TRACK:    rd_mux = trk_q;
      SEL_SECTOR:   rd_mux = sec_q;
      default:      rd_mux = dat_q;
    endcase
    rdata_oe = cs && rd;
    rdata    = rdata_oe ? rd_mux : '0;
  end

  assign seek_target = dat_q;
endmodule

// File: rtl/fdc_regbank_chk.sv
module fdc_regbank_chk #(
  parameter int unsigned REG_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs,
  input logic             wr,
  input logic [1:0]       addr,
  input logic [REG_W-1:0] wdata,
  input logic             busy,
  input logic             step,
  input logic             step_in,
  input logic             wprot_n,
  input logic [REG_W-1:0] rdata,
  input logic             rdata_oe,
  input logic             cmd_start,
  input logic             wp_abort,
  input logic [REG_W-1:0] trk_q,
  input logic [REG_W-1:0] sec_q
);
  logic host_trk_ld, cmd_wr_fint, cmd_wr_prot;

  always_comb begin
    host_trk_ld = cs && wr && (addr == 2'd1) && !busy;
    cmd_wr_fint = cs && wr && (addr == 2'd0) && (wdata[REG_W-1 -: 4] == 4'hD);
    cmd_wr_prot = cs && wr && (addr == 2'd0) && !busy && !wprot_n &&
                  ((wdata[REG_W-1 -: 3] == 3'b101) || (wdata[REG_W-1 -: 4] == 4'hF));
  end

  p_step_up_r7: assert property (@(posedge clk) disable iff (!rst_n)
    step && step_in && !host_trk_ld && (trk_q != '1) |=> trk_q == $past(trk_q) + 1'b1);

  p_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
    step && !step_in && !host_trk_ld && (trk_q == '0) |=> trk_q == '0);

  p_sec_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cs && wr && (addr == 2'd2) |=> $stable(sec_q));

  p_fint_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr_fint |=> cmd_start);

  p_prot_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr_prot |=> wp_abort && !cmd_start);

  p_pulse_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_start && wp_abort));

  p_quiet_bus_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rdata_oe |-> rdata == '0);
endmodule

bind fdc_regbank fdc_regbank_chk #(.REG_W(REG_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs        (cs),
  .wr        (wr),
  .addr      (addr),
  .wdata     (wdata),
  .busy      (busy),
  .step      (step),
  .step_in   (step_in),
  .wprot_n   (wprot_n),
  .rdata     (rdata),
  .rdata_oe  (rdata_oe),
  .cmd_start (cmd_start),
  .wp_abort  (wp_abort),
  .trk_q     (trk_q),
  .sec_q     (sec_q)
);

// File: tb/test_fdc_regbank.sv
`timescale 1ns/1ps
module test_fdc_regbank;
  logic       clk, rst_n;
  logic       cs, rd, wr, busy, seq_stat_we, step, step_in, id_valid, wprot_n;
  logic [1:0] addr;
  logic [7:0] wdata, id_trk, id_sec;
  logic [7:1] seq_stat;
  logic [7:0] rdata, cmd_code, seek_target;
  logic       rdata_oe, trk_match, sec_match, cmd_start, wp_abort;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // behavioural reference state
  logic [7:0] m_trk, m_sec, m_dat, m_cmd;
  logic [7:1] m_st;
  bit         m_start, m_abort, m_tm, m_sm;

  fdc_regbank i_fdc_regbank (
    .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe), .busy(busy),
    .seq_stat_we(seq_stat_we), .seq_stat(seq_stat), .step(step),
    .step_in(step_in), .id_valid(id_valid), .id_trk(id_trk), .id_sec(id_sec),
    .trk_match(trk_match), .sec_match(sec_match), .wprot_n(wprot_n),
    .cmd_code(cmd_code), .cmd_start(cmd_start), .wp_abort(wp_abort),
    .seek_target(seek_target)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_trk = 0; m_sec = 0; m_dat = 0; m_cmd = 0; m_st = 0;
      m_start = 0; m_abort = 0; m_tm = 0; m_sm = 0;
    end else begin
      automatic bit w     = cs && wr;
      automatic bit acc   = w && addr == 0 && (!busy || wdata[7:4] == 4'hD);
      automatic bit iswr  = (wdata[7:5] == 3'b101) || (wdata[7:4] == 4'hF);
      automatic bit abort = acc && iswr && !wprot_n;
      m_start = acc && !abort;
      m_abort = abort;
      if (acc) m_cmd = wdata;
      if (seq_stat_we) m_st = seq_stat;
      if (abort) m_st[6] = 1'b1;
      else if (m_start) m_st[6] = 1'b0;
      if (id_valid) begin
        m_tm = (id_trk == m_trk);
        m_sm = (id_sec == m_sec);
      end
      if (w && addr == 1 && !busy) m_trk = wdata;
      else if (step && step_in && m_trk != 8'hFF) m_trk = m_trk + 1;
      else if (step && !step_in && m_trk != 8'h00) m_trk = m_trk - 1;
      if (w && addr == 2 && !busy) m_sec = wdata;
      if (w && addr == 3) m_dat = wdata;
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] exp_read();
    case (addr)
      2'd0:    return {m_st, busy};
      2'd1:    return m_trk;
      2'd2:    return m_sec;
      default: return m_dat;
    endcase
  endfunction

  // wait one clock, then compare every output with the model
  task automatic tick();
    @(negedge clk);
    chk("R9 cmd_start", cmd_start, m_start);
    chk("R9 wp_abort", wp_abort, m_abort);
    chk("R6 cmd_code", cmd_code, m_cmd);
    chk("R11 seek_target", seek_target, m_dat);
    chk("R8 trk_match", trk_match, m_tm);
    chk("R8 sec_match", sec_match, m_sm);
    chk("R10 rdata_oe", rdata_oe, cs && rd);
    chk("R2/R3 rdata", rdata, (cs && rd) ? exp_read() : 8'h00);
  endtask

  task automatic idle();
    cs = 0; rd = 0; wr = 0; addr = 0; wdata = 0; seq_stat_we = 0;
    step = 0; id_valid = 0;
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    idle(); cs = 1; wr = 1; addr = a; wdata = d;
    tick(); idle();
  endtask

  task automatic bus_read(input logic [1:0] a, input string tag, input logic [7:0] exp);
    idle(); cs = 1; rd = 1; addr = a;
    #1 chk(tag, rdata, exp);
    tick(); idle();
  endtask

  task automatic do_step(input logic dir);
    idle(); step = 1; step_in = dir;
    tick(); idle();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; busy = 0; wprot_n = 1; step_in = 0; seq_stat = 0;
    id_trk = 0; id_sec = 0; idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset values
    chk("R1 cmd_start", cmd_start, 0);
    chk("R1 match", {trk_match, sec_match}, 0);
    bus_read(2'd0, "R1 status", 8'h00);
    bus_read(2'd1, "R1 track", 8'h00);
    bus_read(2'd2, "R1 sector", 8'h00);
    bus_read(2'd3, "R1 data", 8'h00);

    // R2 write and read back
    bus_write(2'd1, 8'h10);
    bus_write(2'd2, 8'h05);
    bus_write(2'd3, 8'h2A);
    bus_read(2'd1, "R2 track", 8'h10);
    bus_read(2'd2, "R2 sector", 8'h05);
    bus_read(2'd3, "R2 data", 8'h2A);
    chk("R11 seek", seek_target, 8'h2A);

    // R4 sequencer status load, R3 status read with live busy
    idle(); seq_stat_we = 1; seq_stat = 7'b0010010; tick(); idle();
    busy = 1;
    bus_read(2'd0, "R3 status busy", 8'h25);
    busy = 0;
    bus_read(2'd0, "R4 status idle", 8'h24);
    bus_write(2'd0, 8'h1B);
    bus_read(2'd0, "R3 cmd not readable", 8'h24);

    // R5 lockout while busy
    busy = 1;
    bus_write(2'd1, 8'h33);
    bus_write(2'd2, 8'h44);
    bus_write(2'd0, 8'h80);
    bus_write(2'd3, 8'h55);
    bus_read(2'd1, "R5 track locked", 8'h10);
    bus_read(2'd2, "R5 sector locked", 8'h05);
    bus_read(2'd3, "R5 data open", 8'h55);
    chk("R5 cmd locked", cmd_code, 8'h1B);

    // R6 force interrupt while busy
    idle(); cs = 1; wr = 1; addr = 0; wdata = 8'hD3; tick(); idle();
    chk("R6 start pulse", cmd_start, 1);
    chk("R6 code", cmd_code, 8'hD3);
    tick();
    chk("R6 one cycle", cmd_start, 0);
    busy = 0;

    // R7 stepping and saturation
    do_step(1); do_step(1);
    bus_read(2'd1, "R7 step in", 8'h12);
    bus_write(2'd1, 8'h01);
    do_step(0); do_step(0); do_step(0);
    bus_read(2'd1, "R7 floor", 8'h00);
    bus_write(2'd1, 8'hFE);
    do_step(1); do_step(1); do_step(1);
    bus_read(2'd1, "R7 ceiling", 8'hFF);
    idle(); cs = 1; wr = 1; addr = 1; wdata = 8'h40; step = 1; step_in = 0;
    tick(); idle();
    bus_read(2'd1, "R7 write beats step", 8'h40);

    // R8 ID compare
    idle(); id_valid = 1; id_trk = 8'h40; id_sec = 8'h05; tick(); idle();
    chk("R8 both match", {trk_match, sec_match}, 2'b11);
    id_trk = 8'h41; tick();
    chk("R8 held", {trk_match, sec_match}, 2'b11);
    idle(); id_valid = 1; tick(); idle();
    chk("R8 track miss", {trk_match, sec_match}, 2'b01);

    // R9 write-protect
    wprot_n = 0;
    bus_write(2'd0, 8'hA0);
    chk("R9 abort", {wp_abort, cmd_start}, 2'b10);
    bus_read(2'd0, "R9 wp bit set", 8'h64);
    bus_write(2'd0, 8'h00);
    chk("R9 non-write ok", {wp_abort, cmd_start}, 2'b01);
    bus_read(2'd0, "R9 wp bit clear", 8'h24);
    bus_write(2'd0, 8'hF4);
    chk("R9 write track abort", wp_abort, 1);
    wprot_n = 1;
    bus_write(2'd0, 8'hA2);
    chk("R9 unprotected", {wp_abort, cmd_start}, 2'b01);

    // R10 no drive without both strobes
    idle(); rd = 1; addr = 1; #1;
    chk("R10 rd without cs", {rdata_oe, rdata}, 0);
    tick(); idle();

    repeat (3) tick();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule